// File: doc/BRIEF.md
# Debug interrupt source controller

This block gathers two debugger-side events, an abort request and a message-received notice, into a single interrupt toward an embedded core. Both events arrive from the JTAG clock domain as level signals. The block takes each rising edge as one event. It synchronizes that edge into the main clock domain and records it in a per-source status bit. The core reads the status bits and clears them on the peripheral bus by writing ones.

A mask register decides which sources may drive the interrupt. It can be loaded only through a JTAG-side load port, and only while the mask scan instruction is selected. The peripheral bus has no path to it. A masked source still records its status bit but stays silent on the interrupt outputs. While the chip sits in its idle power mode, any pending unmasked source also raises a wake request.

Everything runs on the main clock. The block therefore keeps working when the JTAG clock is stopped.

Top module: `dbg_irq_ctl`

## Requirements
- R1: After reset the status bits, the mask bits, `irq_o`, `pend_o` and `wake_o` are all 0.
- R2: A rising edge on `src_evt_i[i]` sets status bit i (bit 0 = abort, bit 1 = message received). The bit becomes visible on `stat_o` after the third rising clock edge following the input change: two synchronizer stages, then the status register.
- R3: A bus write with a 1 in bit i of `bus_wdata_i` clears status bit i. A 0 in bit i leaves that bit unchanged.
- R4: `pend_o` is high while any unmasked status bit is 1. It falls only once every unmasked bit is 0.
- R5: When a source event and a bus write clearing the same bit land on the same clock edge, the bit stays set and `irq_o` pulses.
- R6: `irq_o` is a one-cycle pulse for each unmasked source event, in the same cycle the status bit shows set. An event on a second source while the first is pending pulses `irq_o` again, sets both bits and keeps `pend_o` high.
- R7: The mask loads from `mask_val_i` only on a clock edge where both `mask_ld_i` and `mask_sel_i` are 1. A mask bit of 1 masks that source.
- R8: A masked source event still sets its status bit, but it raises neither `irq_o` nor `pend_o` nor `wake_o`.
- R9: `wake_o` equals `pend_o` while `lp_mode_i` is 1 (idle) and is 0 while `lp_mode_i` is 0 (active).
- R10: A source input held high produces a single event. Once its bit is cleared, it stays clear until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | NSRC | Source event levels from the JTAG domain (bit 0 abort, bit 1 message received) |
| bus_wr_i | input | 1 | Peripheral bus write strobe to the status register |
| bus_wdata_i | input | NSRC | Write data; a 1 clears the matching status bit |
| mask_sel_i | input | 1 | Mask scan instruction is selected |
| mask_ld_i | input | 1 | JTAG-side mask load strobe |
| mask_val_i | input | NSRC | Mask value to load (1 = masked) |
| lp_mode_i | input | 1 | Power mode: 0 active, 1 idle |
| stat_o | output | NSRC | Status bits, readable on the peripheral bus |
| irq_o | output | 1 | Interrupt pulse |
| pend_o | output | 1 | Level: an unmasked source is pending |
| wake_o | output | 1 | Wake request in idle mode |

## Verification
The bench builds the block with NSRC = 2 and SYNC_STAGES = 2, the real source count and a standard two-flop synchronizer. With these values the full latency from input edge to status bit is three clock edges, which lets the bench place a clearing write exactly on the edge where the event lands. Two sources are enough to reach the nested-event case, partial clears and a mixed masked/unmasked pair.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;

    // Source bit positions as seen in the status register.
    localparam int SRC_ABORT   = 0;
    localparam int SRC_MSG_RX  = 1;
    localparam int NUM_SRC     = 2;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic {
        PWR_ACTIVE = 1'b0,
        PWR_IDLE   = 1'b1
    } pwr_mode_e;

    // One status update: bits to set and bits to clear on this edge.
    typedef struct packed {
        logic [NUM_SRC-1:0] set;
        logic [NUM_SRC-1:0] clr;
    } stat_upd_t;

    // Set has priority over clear on the same edge.
    function automatic logic [NUM_SRC-1:0] apply_upd(
        input logic [NUM_SRC-1:0] cur,
        input stat_upd_t          upd
    );
        return (cur & ~upd.clr) | upd.set;
    endfunction

endpackage

// File: rtl/dbg_evt_sync.sv
module dbg_evt_sync #(
    parameter int NSRC   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] async_i,
    output logic [NSRC-1:0] rise_o
);
    localparam int SHW = STAGES + 1;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [SHW-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[SHW-2:0], async_i[i]};
        end
        // Rising edge of the synchronized level.
        assign rise_o[i] = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/dbg_src_stat.sv
module dbg_src_stat
    import dbg_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] stat_o
);
    stat_upd_t upd;

    always_comb begin
        upd.set = set_i;
        upd.clr = wr_i ? wdata_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_o <= '0;
        else     stat_o <= apply_upd(stat_o, upd);
    end
endmodule

// File: rtl/dbg_mask_reg.sv
module dbg_mask_reg #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_i,
    input  logic            ld_i,
    input  logic [NSRC-1:0] val_i,
    output logic [NSRC-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (rst)                mask_o <= '0;
        else if (sel_i && ld_i) mask_o <= val_i;
    end
endmodule

// File: rtl/dbg_irq_ctl.sv
module dbg_irq_ctl
    import dbg_irq_pkg::*;
#(
    parameter int NSRC        = NUM_SRC,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_evt_i,
    input  logic            bus_wr_i,
    input  logic [NSRC-1:0] bus_wdata_i,
    input  logic            mask_sel_i,
    input  logic            mask_ld_i,
    input  logic [NSRC-1:0] mask_val_i,
    input  logic            lp_mode_i,
    output logic [NSRC-1:0] stat_o,
    output logic            irq_o,
    output logic            pend_o,
    output logic            wake_o
);
    logic [NSRC-1:0] evt_edge;
    logic [NSRC-1:0] mask_q;
    logic            irq_q;
    pwr_mode_e       mode;

    dbg_evt_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (src_evt_i),
        .rise_o  (evt_edge)
    );

    dbg_src_stat u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_i   (evt_edge),
        .wr_i    (bus_wr_i),
        .wdata_i (bus_wdata_i),
        .stat_o  (stat_o)
    );

    dbg_mask_reg #(.NSRC(NSRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (mask_sel_i),
        .ld_i   (mask_ld_i),
        .val_i  (mask_val_i),
        .mask_o (mask_q)
    );

    // One pulse per unmasked event, aligned with the status update.
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(evt_edge & ~mask_q);
    end

    assign mode   = pwr_mode_e'(lp_mode_i);
    assign irq_o  = irq_q;
    assign pend_o = |(stat_o & ~mask_q);
    assign wake_o = pend_o && (mode == PWR_IDLE);
endmodule

// File: rtl/dbg_irq_ctl_chk.sv
module dbg_irq_ctl_chk #(
    parameter int NSRC = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] evt_edge,
    input logic [NSRC-1:0] mask_q,
    input logic            bus_wr_i,
    input logic [NSRC-1:0] bus_wdata_i,
    input logic            mask_sel_i,
    input logic            mask_ld_i,
    input logic [NSRC-1:0] stat_o,
    input logic            irq_o,
    input logic            pend_o,
    input logic            wake_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
            evt_edge[i] |=> stat_o[i]);
        p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
            (bus_wr_i && bus_wdata_i[i] && !evt_edge[i]) |=> !stat_o[i]);
        p_zero_keeps_r3: assert property (@(posedge clk) disable iff (rst)
            (stat_o[i] && !(bus_wr_i && bus_wdata_i[i])) |=> stat_o[i]);
    end

    p_irq_pending_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pend_o);
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(mask_ld_i && mask_sel_i) |=> $stable(mask_q));
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (evt_edge != '0 && (evt_edge & ~mask_q) == '0) |=> !irq_o);
    p_wake_needs_status_r9: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (pend_o && stat_o != '0));
endmodule

bind dbg_irq_ctl dbg_irq_ctl_chk #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_edge    (evt_edge),
    .mask_q      (mask_q),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .mask_sel_i  (mask_sel_i),
    .mask_ld_i   (mask_ld_i),
    .stat_o      (stat_o),
    .irq_o       (irq_o),
    .pend_o      (pend_o),
    .wake_o      (wake_o)
);

// File: tb/sim_dbg_irq_ctl.sv
module sim_dbg_irq_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 2;
    // Table entries {preset bits, write data, expected status}.
    localparam logic [5:0] W1C_VEC [8] = '{
        6'b11_01_10, 6'b11_10_01, 6'b11_00_11, 6'b11_11_00,
        6'b01_10_01, 6'b10_01_10, 6'b01_01_00, 6'b10_11_00
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_evt_i = '0;
    logic            bus_wr_i = 1'b0;
    logic [NSRC-1:0] bus_wdata_i = '0;
    logic            mask_sel_i = 1'b0;
    logic            mask_ld_i = 1'b0;
    logic [NSRC-1:0] mask_val_i = '0;
    logic            lp_mode_i = 1'b0;
    logic [NSRC-1:0] stat_o;
    logic            irq_o, pend_o, wake_o;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_irq_ctl #(.NSRC(NSRC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .src_evt_i(src_evt_i), .bus_wr_i(bus_wr_i),
        .bus_wdata_i(bus_wdata_i), .mask_sel_i(mask_sel_i), .mask_ld_i(mask_ld_i),
        .mask_val_i(mask_val_i), .lp_mode_i(lp_mode_i), .stat_o(stat_o),
        .irq_o(irq_o), .pend_o(pend_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Raise inputs; return just after the edge where status updates.
    task automatic raise(input logic [NSRC-1:0] bits);
        src_evt_i = bits;
        repeat (3) @(negedge clk);
    endtask

    task automatic drop_all();
        src_evt_i = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_write(input logic [NSRC-1:0] d);
        bus_wr_i = 1'b1; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic load_mask(input logic sel, input logic [NSRC-1:0] v);
        mask_sel_i = sel; mask_ld_i = 1'b1; mask_val_i = v;
        @(negedge clk);
        mask_sel_i = 1'b0; mask_ld_i = 1'b0; mask_val_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 stat", stat_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 pend", pend_o, 0);
        check("R1 wake", wake_o, 0);

        // R3 write-one-clear table walk
        for (int k = 0; k < 8; k++) begin
            raise(W1C_VEC[k][5:4]);
            drop_all();
            bus_write(W1C_VEC[k][3:2]);
            check("R3 w1c table", stat_o, W1C_VEC[k][1:0]);
            check("R4 pend level", pend_o, W1C_VEC[k][1:0] != 0);
            bus_write(2'b11);
        end

        // R2 latency and R6 pulse
        src_evt_i = 2'b01;
        repeat (2) @(negedge clk);
        check("R2 not yet set", stat_o, 0);
        @(negedge clk);
        check("R2 abort set", stat_o, 2'b01);
        check("R6 irq pulse", irq_o, 1);
        @(negedge clk);
        check("R6 pulse one cycle", irq_o, 0);
        drop_all();
        // R6 nested second source
        raise(2'b10);
        check("R6 nested irq", irq_o, 1);
        check("R6 nested stat", stat_o, 2'b11);
        check("R6 nested pend", pend_o, 1);
        drop_all();
        // R4 partial clear keeps pend
        bus_write(2'b01);
        check("R4 partial pend", pend_o, 1);
        bus_write(2'b10);
        check("R4 all clear pend", pend_o, 0);

        // R5 set wins over simultaneous clear
        src_evt_i = 2'b01;
        repeat (2) @(negedge clk);
        bus_write(2'b01);
        check("R5 bit kept", stat_o, 2'b01);
        check("R5 irq refires", irq_o, 1);

        // R10 held input: no further event
        repeat (3) @(negedge clk);
        bus_write(2'b01);
        repeat (4) @(negedge clk);
        check("R10 stays clear", stat_o, 0);
        check("R10 no irq", irq_o, 0);
        drop_all();

        // R7 load without select ignored
        load_mask(1'b0, 2'b01);
        raise(2'b01);
        check("R7 unselected load ignored", irq_o, 1);
        drop_all();
        bus_write(2'b11);
        // R7/R8 selected load masks abort
        load_mask(1'b1, 2'b01);
        lp_mode_i = 1'b1;
        raise(2'b01);
        check("R8 masked stat set", stat_o, 2'b01);
        check("R8 masked no irq", irq_o, 0);
        check("R8 masked no pend", pend_o, 0);
        check("R8 masked no wake", wake_o, 0);
        drop_all();
        raise(2'b10);
        check("R7 unmasked irq", irq_o, 1);
        drop_all();
        // R9 wake follows mode
        check("R9 idle wake", wake_o, 1);
        lp_mode_i = 1'b0;
        #1;
        check("R9 active no wake", wake_o, 0);
        check("R9 active pend", pend_o, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule